// File: doc/BRIEF.md
# Phase-Aligned Multi-Bank Clock Divider

This block divides one fast source clock into four output clocks: bank A, bank B, bank C and a feedback bank. Each bank's divide ratio comes from a shared range-select input and the bank's own select input or inputs. A mix of ratios, including 12, 24 and 48, can be active at the same time. Every output has an exact 50% duty cycle.

All four banks are timed from one master counter of period 96, which is the least common multiple of every ratio. Because of this, the rising edges of the banks always coincide and fixed ratios such as 3:2:1 hold between them. A synchronous reset acts as the power-on reset. It clears the outputs and lines up every bank, so that all enabled outputs rise together on the first source edge after release.

Select inputs are taken only at the master wrap. A ratio change therefore cannot shorten a high or a low phase. Each bank also has an enable that takes effect only at that bank's falling-edge boundary.

Top module: `clkdiv_banks`

## Requirements
- R1: While `rst` is high, every bit of `bank_clk` is 0. On the first rising edge of `clk_src` with `rst` low, every enabled bank drives 1.
- R2: Bank A (`bank_clk[0]`) divides by 4, 8, 8 or 16 for {`range_sel`,`sel_a`} = 00, 01, 10 and 11.
- R3: Bank B (`bank_clk[1]`) divides by 4, 8, 8 or 16 for {`range_sel`,`sel_b`} = 00, 01, 10 and 11.
- R4: Bank C (`bank_clk[2]`) divides by 8, 12, 16 or 24 for {`range_sel`,`sel_c`} = 00, 01, 10 and 11.
- R5: The feedback bank (`bank_clk[3]`) divides by 8, 16, 12, 24, 16, 32, 24 or 48 for {`range_sel`,`sel_fb[1]`,`sel_fb[0]`} = 000 through 111, in that order.
- R6: For a ratio N, every output is high for exactly N/2 source cycles and low for exactly N/2 source cycles. No phase is ever shorter than 2 cycles.
- R7: Counting source edges after reset release from 0, a bank with ratio N rises only on edges whose count is a multiple of N. All enabled banks rise together on edge 0 and on every multiple of 96.
- R8: Select inputs are taken only on edges whose count after release is a multiple of 96. A change at any other time has no effect until the next such edge.
- R9: `bank_en[i]` is taken only on the edge where bank i enters its low half, which is count mod N = N/2. A disabled bank stays low from that point. A re-enabled bank next rises at its normal rising edge.
- R10: Selects and enables present during reset apply from the first edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous reset, active high, acts as power-on reset |
| range_sel | input | 1 | Range select shared by all banks |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| sel_fb | input | 2 | Feedback bank ratio select |
| bank_en | input | 4 | Per-bank enable: bit 0 A, 1 B, 2 C, 3 feedback |
| bank_clk | output | 4 | Divided outputs: bit 0 A, 1 B, 2 C, 3 feedback |

## Verification
A wrong master count or bank phase shows up at the ports as a rising edge that drifts away from the other banks. It is visible on the first misplaced edge, at most one output period (48 cycles) after the fault. A wrongly latched ratio or enable shows up as a period, high time or gating change in the wrong 96-cycle window, or in the middle of a high phase. The bench predicts every output on every cycle from the edge count after release and compares the prediction with all four banks, so any of these errors is caught on the cycle it appears.

// File: rtl/clkdiv_banks.sv
module clkdiv_banks #(
  parameter int MODV = 96
) (
  input  logic       clk_src,
  input  logic       rst,
  input  logic       range_sel,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       sel_c,
  input  logic [1:0] sel_fb,
  input  logic [3:0] bank_en,
  output logic [3:0] bank_clk
);
  localparam int CW = $clog2(MODV);
  localparam int NB = 4;

  logic [CW-1:0] cnt;
  logic          wrap;
  logic [NB-1:0] en_q;
  logic [CW-1:0] req [NB];

  assign wrap = (cnt == CW'(MODV - 1));

  always_ff @(posedge clk_src) begin
    if (rst || wrap) cnt <= (rst ? CW'(MODV - 1) : '0);
    else             cnt <= cnt + 1'b1;
  end

  always_comb begin
    case ({range_sel, sel_a})
      2'b00:   req[0] = CW'(4);
      2'b11:   req[0] = CW'(16);
      default: req[0] = CW'(8);
    endcase
    case ({range_sel, sel_b})
      2'b00:   req[1] = CW'(4);
      2'b11:   req[1] = CW'(16);
      default: req[1] = CW'(8);
    endcase
    case ({range_sel, sel_c})
      2'b00:   req[2] = CW'(8);
      2'b01:   req[2] = CW'(12);
      2'b10:   req[2] = CW'(16);
      default: req[2] = CW'(24);
    endcase
    case ({range_sel, sel_fb})
      3'b000:  req[3] = CW'(8);
      3'b001:  req[3] = CW'(16);
      3'b010:  req[3] = CW'(12);
      3'b011:  req[3] = CW'(24);
      3'b100:  req[3] = CW'(16);
      3'b101:  req[3] = CW'(32);
      3'b110:  req[3] = CW'(24);
      default: req[3] = CW'(48);
    endcase
  end

  for (genvar g = 0; g < NB; g++) begin : bank
    logic [CW-1:0] rat_q, rat_nx, ph_q, ph_nx;
    logic          en_r, en_nx, clk_r;

    assign rat_nx = wrap ? req[g] : rat_q;
    assign ph_nx  = (wrap || ph_q == rat_q - 1'b1) ? '0 : ph_q + 1'b1;
    assign en_nx  = (ph_nx == (rat_nx >> 1)) ? bank_en[g] : en_r;

    always_ff @(posedge clk_src) begin
      if (rst) begin
        rat_q <= req[g];
        ph_q  <= '0;
        en_r  <= bank_en[g];
        clk_r <= 1'b0;
      end else begin
        rat_q <= rat_nx;
        ph_q  <= ph_nx;
        en_r  <= en_nx;
        clk_r <= en_nx && (ph_nx < (rat_nx >> 1));
      end
    end

    assign bank_clk[g] = clk_r;
    assign en_q[g]     = en_r;
  end
endmodule

module clkdiv_banks_chk #(
  parameter int MODV = 96,
  parameter int CW   = 7
) (
  input logic          clk_src,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic [3:0]    en_q,
  input logic [3:0]    bank_clk
);
  // R1
  reset_low_chk: assert property (@(posedge clk_src) rst |=> bank_clk == 4'b0000);

  // R8
  count_range_chk: assert property (@(posedge clk_src) disable iff (rst) cnt < CW'(MODV));

  for (genvar g = 0; g < 4; g++) begin : per_bank
    // R7
    rise_on_grid_chk: assert property (@(posedge clk_src) disable iff (rst)
      $rose(bank_clk[g]) |-> cnt[1:0] == 2'b00);
    // R6
    high_min_chk: assert property (@(posedge clk_src) disable iff (rst)
      $fell(bank_clk[g]) |-> $past(bank_clk[g], 2));
    // R6
    low_min_chk: assert property (@(posedge clk_src) disable iff (rst)
      $rose(bank_clk[g]) |-> !$past(bank_clk[g], 2));
    // R9
    enable_at_low_chk: assert property (@(posedge clk_src) disable iff (rst)
      !$stable(en_q[g]) |-> !bank_clk[g]);
  end
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.MODV(MODV), .CW(CW)) u_chk (
  .clk_src(clk_src), .rst(rst), .cnt(cnt), .en_q(en_q), .bank_clk(bank_clk)
);

// File: tb/clkdiv_banks_test.sv
module clkdiv_banks_test;
  localparam int PER = 10;

  logic       clk_src = 1'b0;
  logic       rst = 1'b1;
  logic       range_sel = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic [1:0] sel_fb = 2'b00;
  logic [3:0] bank_en = 4'hF;
  logic [3:0] bank_clk;

  int checks = 0, errors = 0;
  int k = 0;
  int rat_m [4];
  logic [3:0] en_m, exp_clk;

  clkdiv_banks uut (
    .clk_src(clk_src), .rst(rst), .range_sel(range_sel), .sel_a(sel_a),
    .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb), .bank_en(bank_en),
    .bank_clk(bank_clk)
  );

  always #(PER/2) clk_src = ~clk_src;

  function automatic int dec_ab(logic r, logic s);
    return (r == 1'b0 && s == 1'b0) ? 4 : (r && s) ? 16 : 8;
  endfunction
  function automatic int dec_c(logic r, logic s);
    case ({r, s}) 2'b00: return 8; 2'b01: return 12; 2'b10: return 16; default: return 24; endcase
  endfunction
  function automatic int dec_fb(logic r, logic [1:0] s);
    case ({r, s})
      3'd0: return 8;  3'd1: return 16; 3'd2: return 12; 3'd3: return 24;
      3'd4: return 16; 3'd5: return 32; 3'd6: return 24; default: return 48;
    endcase
  endfunction

  always @(posedge clk_src) begin
    int kk, ph;
    if (rst || k % 96 == 0) begin
      rat_m[0] = dec_ab(range_sel, sel_a);
      rat_m[1] = dec_ab(range_sel, sel_b);
      rat_m[2] = dec_c(range_sel, sel_c);
      rat_m[3] = dec_fb(range_sel, sel_fb);
    end
    if (rst) begin
      k = 0;
      en_m = bank_en;
      exp_clk = 4'b0000;
    end else begin
      kk = k % 96;
      for (int b = 0; b < 4; b++) begin
        ph = kk % rat_m[b];
        if (ph == rat_m[b] / 2) en_m[b] = bank_en[b];
        exp_clk[b] = en_m[b] && (ph < rat_m[b] / 2);
      end
      k = k + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk_src);
    rst = 1'b0;
  endtask

  task automatic compare(input string req, input int cycles);
    int bad [4];
    int act_f [4];
    int exp_f [4];
    for (int b = 0; b < 4; b++) begin bad[b] = 0; act_f[b] = 0; exp_f[b] = 0; end
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_src);
      for (int b = 0; b < 4; b++)
        if (bank_clk[b] !== exp_clk[b]) begin
          if (bad[b] == 0) begin act_f[b] = bank_clk[b]; exp_f[b] = exp_clk[b]; end
          bad[b]++;
        end
    end
    for (int b = 0; b < 4; b++)
      chk(bad[b] == 0, $sformatf("%s bank %0d", req, b), act_f[b], exp_f[b]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_src);
      range_sel = i[0]; sel_a = i[1]; sel_fb = i[1:0];
      chk(bank_clk == 4'b0000, "R1 outputs low in reset", bank_clk, 0);
    end
  endtask

  task automatic t_combos();
    for (int c = 0; c < 8; c++) begin
      range_sel = c[2]; sel_fb = c[1:0]; sel_a = c[0]; sel_b = c[1]; sel_c = c[0] ^ c[1];
      bank_en = 4'hF;
      do_reset();
      @(negedge clk_src);
      chk(bank_clk == 4'hF, "R1 R7 R10 aligned first rise", bank_clk, 15);
      compare("R2 R3 R4 R5 R6 R7 R10 ratios", 200);
    end
  endtask

  task automatic t_change();
    range_sel = 1'b0; sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0; sel_fb = 2'b00;
    bank_en = 4'hF;
    do_reset();
    compare("R8 before change", 37);
    range_sel = 1'b1; sel_a = 1'b1; sel_b = 1'b1; sel_c = 1'b1; sel_fb = 2'b11;
    compare("R8 held until wrap", 59);
    compare("R8 after wrap", 200);
  endtask

  task automatic t_enable();
    range_sel = 1'b0; sel_a = 1'b0; sel_b = 1'b1; sel_c = 1'b1; sel_fb = 2'b01;
    bank_en = 4'hF;
    do_reset();
    compare("R9 all enabled", 9);
    bank_en = 4'b1010;
    compare("R9 partial disable", 31);
    bank_en = 4'b0101;
    compare("R9 swapped enables", 43);
    bank_en = 4'hF;
    compare("R9 re-enabled", 70);
  endtask

  initial begin
    t_reset();
    t_combos();
    t_change();
    t_enable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PER * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule